// File: doc/BRIEF.md
# Refresh-Hiding Pseudo-SRAM Controller

This block makes a set of dynamic-cell storage banks look like an ordinary synchronous SRAM. The requester drives an enable, a write enable, a word address and write data. A read returns its word on the next clock edge, with no wait states. No precharge, refresh or open-row state is visible at the port. Each access opens one row of one bank, senses it and closes it in that same cycle. A row cache holds one line per row index, which gives it the capacity of one bank. Each line carries a bank tag and a valid bit.

Refresh runs beside the accesses and never stalls them. Every bank that the current access does not address refreshes one of its rows in that cycle. When an access hits the row cache, the addressed bank is also free, so it refreshes a row as well. Every bank keeps a round-robin pointer that skips rows already activated or refreshed in the current retention window. The storage arrays are behavioural. Each row has an age counter. A row whose age reaches the retention limit has all of its bits inverted, so a refresh failure shows up as wrong read data.

Top module: `psram_ctrl`

## Requirements
- R1: A read (`en`=1, `we`=0) presents the addressed word on `rdata` after exactly one rising clock edge. The word is the value most recently written to that address.
- R2: `rdata` changes only on a read. Write cycles and idle cycles leave it unchanged.
- R3: While `rst_n` is low, and after it is released, `rdata` is zero until the first read.
- R4: An access that misses the row cache activates the addressed row. This clears the row's age. The whole row, with any write merged in, is loaded into cache line `row` with tag `bank`.
- R5: An access that hits the row cache takes its read data from the cache. In the same cycle the addressed bank refreshes one of its rows not yet touched in the current window.
- R6: In every cycle, each bank that the access does not address refreshes one not-yet-touched row. This includes cycles with no access.
- R7: No row's age reaches `RETENTION` under any access pattern, including endless accesses to one word. Stored data therefore never decays.
- R8: A write updates the bank array always, and also updates the cached line when the tag matches. The written value is returned from the cache and, after eviction, from the array.
- R9: The address splits as {bank, row, col}, with the bank in the most significant bits and col in the least significant bits. Word `col` occupies bits col*DW to col*DW+DW-1 of its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read (when `en`=1) |
| addr | input | ADDR_W | Word address {bank, row, col} |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, one cycle after a read |

## Verification
Reads are checked against a flat reference memory under four patterns. A sequential sweep activates every row in turn, which tests activation as refresh and the cache fill path. Hammering a single word holds one bank busy with cache hits, so only hidden refresh can save its other rows. Alternating two banks at the same row index makes every access evict the other bank's line, so each access misses. Random traffic and a long idle stretch follow. After hammering and after idling, every address is read back, and any row left unrefreshed shows up as inverted data.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // What a bank's array does in a given cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ACT  = 2'd1,
    OP_REF  = 2'd2
  } bank_op_e;
endpackage

// File: rtl/psram_bank.sv
module psram_bank
  import psram_pkg::*;
#(
  parameter int ROWS      = 128,
  parameter int ROW_BITS  = 256,
  parameter int DW        = 32,
  parameter int RETENTION = 1024
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        act_en,
  input  logic [$clog2(ROWS)-1:0]     act_row,
  input  logic                        wr_en,
  input  logic [$clog2(ROWS)-1:0]     wr_row,
  input  logic [$clog2(ROW_BITS/DW)-1:0] wr_col,
  input  logic [DW-1:0]               wr_word,
  input  logic                        ref_en,
  output logic [ROW_BITS-1:0]         row_data,
  output bank_op_e                    op,
  output logic [$clog2(ROWS)-1:0]     ref_row
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int AGE_W = $clog2(RETENTION + 1);

  logic [ROW_BITS-1:0] mem [ROWS];
  logic [AGE_W-1:0]    age [ROWS];
  logic [ROWS-1:0]     fresh;
  logic [ROWS-1:0]     touch;
  logic [ROWS-1:0]     fresh_nx;
  logic [ROW_W-1:0]    ptr;
  logic                stale_any;
  logic                ref_fire;
  logic [AGE_W-1:0]    oldest;

  // First row at or after the pointer that has not been touched this window.
  function automatic logic [ROW_W-1:0] next_stale(input logic [ROWS-1:0] fv,
                                                  input logic [ROW_W-1:0] start);
    logic [ROW_W-1:0] pick;
    logic             found;
    logic [ROW_W-1:0] idx;
    pick  = start;
    found = 1'b0;
    for (int k = 0; k < ROWS; k++) begin
      idx = start + ROW_W'(k);
      if (!found && !fv[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  function automatic logic [AGE_W-1:0] max_age(input logic [AGE_W-1:0] a [ROWS]);
    logic [AGE_W-1:0] m;
    m = '0;
    for (int k = 0; k < ROWS; k++) if (a[k] > m) m = a[k];
    return m;
  endfunction

  assign stale_any = ~&fresh;
  assign ref_row   = next_stale(fresh, ptr);
  assign ref_fire  = ref_en && !act_en && stale_any;
  assign op        = act_en ? OP_ACT : (ref_fire ? OP_REF : OP_IDLE);
  assign row_data  = mem[act_row];
  assign oldest    = max_age(age);

  always_comb begin
    touch = '0;
    if (act_en)        touch[act_row] = 1'b1;
    else if (ref_fire) touch[ref_row] = 1'b1;
    fresh_nx = fresh | touch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh <= '0;
      ptr   <= '0;
      for (int r = 0; r < ROWS; r++) age[r] <= '0;
    end else begin
      fresh <= (&fresh_nx) ? '0 : fresh_nx;
      if (ref_fire) ptr <= ref_row + ROW_W'(1);
      for (int r = 0; r < ROWS; r++) begin
        if (touch[r])                          age[r] <= '0;
        else if (age[r] != AGE_W'(RETENTION))  age[r] <= age[r] + AGE_W'(1);
      end
    end
  end

  // Storage: behavioural cells lose their charge (bits invert) at the limit.
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++)
      if (rst_n && !touch[r] && age[r] == AGE_W'(RETENTION - 1)) mem[r] <= ~mem[r];
    if (wr_en) mem[wr_row][wr_col*DW +: DW] <= wr_word;
  end

  a_r7_age_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    oldest < AGE_W'(RETENTION));
  a_r4_act_clears_age: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> age[$past(act_row)] == '0);
  a_r5_ref_clears_age: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> age[$past(ref_row)] == '0);
endmodule

// File: rtl/psram_row_cache.sv
module psram_row_cache #(
  parameter int ROWS      = 128,
  parameter int ROW_BITS  = 256,
  parameter int DW        = 32,
  parameter int NUM_BANKS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(ROWS)-1:0]        look_row,
  input  logic [$clog2(NUM_BANKS)-1:0]   look_bank,
  output logic                           hit,
  output logic [ROW_BITS-1:0]            line_out,
  input  logic                           fill_en,
  input  logic [ROW_BITS-1:0]            fill_line,
  input  logic                           wr_en,
  input  logic [$clog2(ROW_BITS/DW)-1:0] wr_col,
  input  logic [DW-1:0]                  wr_word
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [ROW_BITS-1:0] line [ROWS];
  logic [BANK_W-1:0]   tag  [ROWS];
  logic [ROWS-1:0]     valid;

  assign hit      = valid[look_row] && (tag[look_row] == look_bank);
  assign line_out = line[look_row];

  always_ff @(posedge clk) begin
    if (!rst_n)       valid <= '0;
    else if (fill_en) valid[look_row] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      line[look_row] <= fill_line;
      tag[look_row]  <= look_bank;
    end else if (wr_en) begin
      line[look_row][wr_col*DW +: DW] <= wr_word;
    end
  end

  a_r4_fill_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid[$past(look_row)] && tag[$past(look_row)] == $past(look_bank));
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 128,
  parameter int ROW_BITS  = 256,
  parameter int DW        = 32,
  parameter int RETENTION = 8 * ROWS,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COLS     = ROW_BITS / DW,
  localparam int COL_W    = $clog2(COLS),
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic [BANK_W-1:0]   req_bank;
  logic [ROW_W-1:0]    req_row;
  logic [COL_W-1:0]    req_col;
  logic                tag_match;
  logic                hit;
  logic                miss;
  logic [ROW_BITS-1:0] cache_line;
  logic [ROW_BITS-1:0] row_rd [NUM_BANKS];
  logic [ROW_BITS-1:0] sel_row;
  logic [ROW_BITS-1:0] fill_line;
  bank_op_e            bank_ops [NUM_BANKS];
  logic [ROW_W-1:0]    ref_rows [NUM_BANKS];

  function automatic logic [DW-1:0] get_word(input logic [ROW_BITS-1:0] ln,
                                             input logic [COL_W-1:0] c);
    return ln[c*DW +: DW];
  endfunction

  function automatic logic [ROW_BITS-1:0] put_word(input logic [ROW_BITS-1:0] ln,
                                                   input logic [COL_W-1:0] c,
                                                   input logic [DW-1:0] w);
    logic [ROW_BITS-1:0] o;
    o = ln;
    o[c*DW +: DW] = w;
    return o;
  endfunction

  assign req_col  = addr[COL_W-1:0];
  assign req_row  = addr[COL_W +: ROW_W];
  assign req_bank = addr[ADDR_W-1 -: BANK_W];
  assign hit      = en && tag_match;
  assign miss     = en && !tag_match;
  assign sel_row  = row_rd[req_bank];
  assign fill_line = we ? put_word(sel_row, req_col, wdata) : sel_row;

  psram_row_cache #(
    .ROWS(ROWS), .ROW_BITS(ROW_BITS), .DW(DW), .NUM_BANKS(NUM_BANKS)
  ) u_cache (
    .clk(clk), .rst_n(rst_n),
    .look_row(req_row), .look_bank(req_bank),
    .hit(tag_match), .line_out(cache_line),
    .fill_en(miss), .fill_line(fill_line),
    .wr_en(hit && we), .wr_col(req_col), .wr_word(wdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic addressed;
    assign addressed = en && (req_bank == BANK_W'(b));

    psram_bank #(
      .ROWS(ROWS), .ROW_BITS(ROW_BITS), .DW(DW), .RETENTION(RETENTION)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_en(addressed && !tag_match), .act_row(req_row),
      .wr_en(addressed && we), .wr_row(req_row), .wr_col(req_col), .wr_word(wdata),
      .ref_en(!(addressed && !tag_match)),
      .row_data(row_rd[b]), .op(bank_ops[b]), .ref_row(ref_rows[b])
    );

    a_r5_hit_frees_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (addressed && hit) |-> bank_ops[b] == OP_REF);
    a_r6_idle_bank_refreshes: assert property (@(posedge clk) disable iff (!rst_n)
      !addressed |-> bank_ops[b] == OP_REF);
    a_r4_miss_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (addressed && miss) |-> bank_ops[b] == OP_ACT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (en && !we)  rdata <= get_word(hit ? cache_line : sel_row, req_col);
  end
endmodule

// File: tb/psram_ctrl_test.sv
`timescale 1ns/1ps
module psram_ctrl_test;
  localparam int NB = 4, ROWS = 16, RB = 64, DW = 16, RET = 8 * ROWS;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;

  always #2 clk = ~clk;

  psram_ctrl #(.NUM_BANKS(NB), .ROWS(ROWS), .ROW_BITS(RB), .DW(DW), .RETENTION(RET))
    uut (.clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [256];
  logic          pend = 0;
  logic [DW-1:0] pend_exp = '0, last_rd = '0;
  string         pend_req = "R1";

  // {we, addr, data, expected read}; addr = {bank[7:6], row[5:2], col[1:0]}
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 8'h00, 16'hA5A5, 16'h0000},
    {1'b1, 8'h41, 16'h1234, 16'h0000},
    {1'b0, 8'h00, 16'h0000, 16'hA5A5},
    {1'b0, 8'h41, 16'h0000, 16'h1234},
    {1'b1, 8'h41, 16'hBEEF, 16'h0000},
    {1'b0, 8'h41, 16'h0000, 16'hBEEF},
    {1'b0, 8'h02, 16'h0000, 16'h02FD},
    {1'b0, 8'hC3, 16'h0000, 16'hC33C}
  };

  task automatic chk(input string rq, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata %h expected %h at %0t", rq, got, exp, $time);
    end
  endtask

  // One access per cycle; the result of the previous cycle is checked first.
  task automatic step(input logic e, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [DW-1:0] ex, input string rq);
    @(negedge clk);
    if (pend) begin
      last_rd = pend_exp;
      chk(pend_req, rdata, last_rd);
    end else begin
      chk("R2 hold", rdata, last_rd);
    end
    en = e; we = w; addr = a; wdata = d;
    pend = e && !w;
    if (pend) begin pend_exp = ex; pend_req = rq; end
    if (e && w) ref_mem[a] = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string rq);
    step(1'b1, 1'b0, a, '0, ref_mem[a], rq);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string rq);
    step(1'b1, 1'b1, a, d, '0, rq);
  endtask

  task automatic idle(input int n, input string rq);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, rq);
  endtask

  task automatic read_all(input string rq);
    for (int a = 0; a < 256; a++) rd(AW'(a), rq);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 in reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 after reset", rdata, '0);

    // R9: every address distinct, data = {addr, ~addr}
    for (int a = 0; a < 256; a++) wr(AW'(a), {AW'(a), ~AW'(a)}, "R9 fill");
    idle(2, "R2 after writes");

    // Vector table: R1 reads, R8 write hit then read
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:16], "R8 table write");
      else step(1'b1, 1'b0, VEC[i][39:32], '0, VEC[i][15:0], "R1/R8 table read");
    end

    // R4: sequential sweep, every row activated and cached
    read_all("R4 sweep");

    // R5/R7: hammer a single word of bank 2
    for (int i = 0; i < 2000; i++) rd(8'h94, "R5 hammer");
    read_all("R7 after hammer");

    // R8: write hit, evict via other bank at same row index, read from array
    rd(8'h25, "R8 prime");
    wr(8'h25, 16'h7E57, "R8 write hit");
    rd(8'hE5, "R8 evict");
    rd(8'h25, "R8 from array");

    // R4: alternate banks at one row index, every access misses
    for (int i = 0; i < 1000; i++) rd((i % 2) ? 8'h1C : 8'h5C, "R4 ping-pong");
    read_all("R7 after ping-pong");

    // R1/R6: random traffic
    for (int i = 0; i < 5000; i++) begin
      logic [AW-1:0] ra;
      int unsigned kind;
      ra   = AW'($urandom_range(0, 255));
      kind = $urandom_range(0, 3);
      if (kind == 0)      wr(ra, DW'($urandom), "R8 random write");
      else if (kind == 1) idle(1, "R2 random idle");
      else                rd(ra, "R1 random read");
    end

    // R6: long idle, only hidden refresh keeps rows alive
    idle(1000, "R6 idle");
    read_all("R6 after idle");
    idle(2, "R2 tail");

    done = 1;
    summary();
    $finish;
  end
endmodule